// File: doc/BRIEF.md
# Ethernet RMON Statistics Counters

This block keeps the frame statistics of an Ethernet MAC. Once per frame the MAC presents a one-cycle report carrying the frame length, the receive or transmit direction, FCS and alignment error flags, the destination address class, a VLAN-tag flag and a pause-frame flag. In that same clock edge the block sorts the frame into error categories and size buckets and bumps every affected counter. Each counter is saturating and `CNT_W` bits wide (64 by default).

Software reads the counters through a registered read port. Each counter occupies two word addresses: the upper half first, then the lower half. A small read state machine has two states. `RD_IDLE` means no snapshot is held. `RD_HELD` means a lower half was captured when its upper half was read. The transition `IDLE->HELD` happens on any upper-half read. `HELD->HELD` happens on a further upper-half read, which re-captures, or on a lower-half read of another counter. `HELD->IDLE` happens on the lower-half read of the captured counter. A short register holds the maximum frame length. It resets to 1536 and can be rewritten at any time.

Top module: `eth_stat_counters`

## Requirements
- R1: After reset every counter reads 0, `rd_data` is 0, the read state machine is in `RD_IDLE`, and the maximum frame length is 1536.
- R2: Counter k sits at address 2k (upper 32 bits, zero-extended) and 2k+1 (lower 32 bits). The indices are: 0 good rx frames, 1 rx octets, 2 unicast, 3 multicast, 4 broadcast, 5 VLAN, 6 FCS errors, 7 alignment errors, 8 undersize, 9 fragments, 10 oversize, 11 jabbers, 12..18 size buckets, 19 rx pause, 20 tx pause, 21 tx frames. Read data appears the cycle after `rd_en`. Addresses 44 and above return 0. `rd_data` holds its value while `rd_en` is low.
- R3: An upper-half read captures the counter's lower half. The next lower-half read of that same counter returns the captured value, even if the counter has changed since. A lower-half read with no capture pending, or of another counter, returns the live value.
- R4: Counters saturate at all ones and never wrap or decrease.
- R5: A receive frame with 64 <= length <= max length goes into exactly one bucket: 12 for length 64, 13 for 65-127, 14 for 128-255, 15 for 256-511, 16 for 512-1023, 17 for 1024-1518, 18 for 1519 to max. FCS and alignment errors do not affect the bucket.
- R6: A receive frame shorter than 64 bytes hits no bucket and is not good. It counts as undersize when its FCS is correct and as a fragment when its FCS is bad.
- R7: A receive frame longer than the max length hits no bucket and is not good. It counts as oversize when its FCS is correct and as a jabber when its FCS is bad.
- R8: Every receive frame with an FCS error bumps counter 6, and every receive frame with an alignment error bumps counter 7, whatever its length.
- R9: A receive frame is good when it has no FCS error, no alignment error and an in-range length. A good frame bumps counter 0. It also bumps one class counter chosen by `rpt_dst`: 0 unicast, 1 multicast, 2 broadcast, 3 none. It bumps the VLAN counter when `rpt_vlan` is set.
- R10: Every receive report adds its length to the octet counter.
- R11: A good receive frame with `rpt_pause` set bumps counter 19. A transmit report bumps counter 21, and also counter 20 when `rpt_pause` is set. A transmit report touches no receive counter.
- R12: A write to the max-length register applies to reports from the next cycle on. A report in the same cycle as the write uses the old value.
- R13: All counters change only at the edge where `rpt_valid` is high, and a read issued one cycle later already sees the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | Frame report present this cycle |
| rpt_is_tx | input | 1 | 1 for a transmitted frame, 0 for a received frame |
| rpt_len | input | LEN_W | Frame length in bytes |
| rpt_fcs_err | input | 1 | FCS check failed |
| rpt_align_err | input | 1 | Alignment error |
| rpt_dst | input | 2 | Destination class: 0 unicast, 1 multicast, 2 broadcast, 3 none |
| rpt_vlan | input | 1 | Frame carried a VLAN tag |
| rpt_pause | input | 1 | Frame is a pause control frame |
| max_len_we | input | 1 | Write strobe for the maximum frame length |
| max_len_wdata | input | LEN_W | New maximum frame length |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Word address: 2k upper half, 2k+1 lower half |
| rd_data | output | 32 | Registered read data |

## Verification
Two things can happen in the same cycle: a counter read and a frame report that changes the counter being read. The bench provokes this by issuing an upper-half read of the octet counter, and other reads, in the very cycle a frame report is applied. It then sends more frames before reading the lower half. The behavioural model evaluates every read against the counter values held before that edge and applies the frame afterwards. The returned pair must therefore match the pre-update 64-bit value, while later live reads show the new totals.

// File: rtl/eth_stat_pkg.sv
package eth_stat_pkg;

    localparam int NUM_CNT   = 22;
    localparam int RD_ADDR_W = $clog2(2 * NUM_CNT);
    localparam int NUM_BKT   = 7;
    localparam int MIN_LEN   = 64;
    localparam int MAX_LEN_RST = 1536;

    localparam int IDX_GOOD   = 0;
    localparam int IDX_OCT    = 1;
    localparam int IDX_UNI    = 2;
    localparam int IDX_MULTI  = 3;
    localparam int IDX_BCAST  = 4;
    localparam int IDX_VLAN   = 5;
    localparam int IDX_FCS    = 6;
    localparam int IDX_ALIGN  = 7;
    localparam int IDX_UNDER  = 8;
    localparam int IDX_FRAG   = 9;
    localparam int IDX_OVER   = 10;
    localparam int IDX_JAB    = 11;
    localparam int IDX_BKT0   = 12;
    localparam int IDX_RXP    = 19;
    localparam int IDX_TXP    = 20;
    localparam int IDX_TXF    = 21;

    typedef enum logic [1:0] {
        DST_UNI   = 2'd0,
        DST_MULTI = 2'd1,
        DST_BCAST = 2'd2,
        DST_NONE  = 2'd3
    } dst_class_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;

    // lower bound of size bucket i
    function automatic int bkt_lo(input int i);
        case (i)
            0: return 64;
            1: return 65;
            2: return 128;
            3: return 256;
            4: return 512;
            5: return 1024;
            default: return 1519;
        endcase
    endfunction

    // upper bound of size bucket i (last one is bounded by max length)
    function automatic int bkt_hi(input int i);
        case (i)
            0: return 64;
            1: return 127;
            2: return 255;
            3: return 511;
            4: return 1023;
            default: return 1518;
        endcase
    endfunction

endpackage

// File: rtl/eth_stat_classify.sv
module eth_stat_classify
    import eth_stat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic               rpt_valid,
    input  logic               rpt_is_tx,
    input  logic [LEN_W-1:0]   rpt_len,
    input  logic               rpt_fcs_err,
    input  logic               rpt_align_err,
    input  logic [1:0]         rpt_dst,
    input  logic               rpt_vlan,
    input  logic               rpt_pause,
    input  logic [LEN_W-1:0]   max_len,
    output logic [NUM_CNT-1:0] inc
);

    logic rx_f, tx_f, short_f, long_f, in_rng, good;
    logic [NUM_BKT-1:0] bkt_hit;

    always_comb begin
        rx_f    = rpt_valid && !rpt_is_tx;
        tx_f    = rpt_valid && rpt_is_tx;
        short_f = rpt_len < LEN_W'(MIN_LEN);
        long_f  = rpt_len > max_len;
        in_rng  = rx_f && !short_f && !long_f;
        good    = in_rng && !rpt_fcs_err && !rpt_align_err;
    end

    for (genvar b = 0; b < NUM_BKT; b++) begin : g_bkt
        if (b == NUM_BKT - 1) begin : g_top
            assign bkt_hit[b] = in_rng && (rpt_len >= LEN_W'(bkt_lo(b)));
        end else begin : g_mid
            assign bkt_hit[b] = in_rng && (rpt_len >= LEN_W'(bkt_lo(b)))
                                       && (rpt_len <= LEN_W'(bkt_hi(b)));
        end
    end

    always_comb begin
        inc                       = '0;
        inc[IDX_GOOD]             = good;
        inc[IDX_OCT]              = rx_f;
        inc[IDX_UNI]              = good && (rpt_dst == DST_UNI);
        inc[IDX_MULTI]            = good && (rpt_dst == DST_MULTI);
        inc[IDX_BCAST]            = good && (rpt_dst == DST_BCAST);
        inc[IDX_VLAN]             = good && rpt_vlan;
        inc[IDX_FCS]              = rx_f && rpt_fcs_err;
        inc[IDX_ALIGN]            = rx_f && rpt_align_err;
        inc[IDX_UNDER]            = rx_f && short_f && !rpt_fcs_err;
        inc[IDX_FRAG]             = rx_f && short_f && rpt_fcs_err;
        inc[IDX_OVER]             = rx_f && long_f && !rpt_fcs_err;
        inc[IDX_JAB]              = rx_f && long_f && rpt_fcs_err;
        inc[IDX_BKT0 +: NUM_BKT]  = bkt_hit;
        inc[IDX_RXP]              = good && rpt_pause;
        inc[IDX_TXP]              = tx_f && rpt_pause;
        inc[IDX_TXF]              = tx_f;
    end

endmodule

// File: rtl/eth_stat_sat_cnt.sv
module eth_stat_sat_cnt #(
    parameter int CNT_W = 64,
    parameter int ADD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [ADD_W-1:0] add_val,
    output logic [CNT_W-1:0] cnt_q
);

    logic [CNT_W:0] sum;

    always_comb sum = {1'b0, cnt_q} + (CNT_W+1)'(add_val);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (add_en) begin
            cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/eth_stat_rdport.sv
module eth_stat_rdport
    import eth_stat_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [RD_ADDR_W-1:0]            rd_addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
    output logic [31:0]                     rd_data,
    output rd_state_e                       rd_state
);

    localparam int IDX_W = RD_ADDR_W - 1;

    rd_state_e        state_q, state_d;
    logic [31:0]      shadow_q;
    logic [IDX_W-1:0] shadow_idx_q;
    logic [31:0]      rd_d;
    logic             shadow_ld;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic [CNT_W-1:0] sel;
    logic [63:0]      sel_ext;

    always_comb begin
        idx     = rd_addr[RD_ADDR_W-1:1];
        idx_ok  = int'(idx) < NUM_CNT;
        sel     = idx_ok ? cnt_all[idx] : '0;
        sel_ext = 64'(sel);
    end

    // next-state and read-data selection
    always_comb begin
        state_d   = state_q;
        rd_d      = rd_data;
        shadow_ld = 1'b0;
        if (rd_en) begin
            if (!idx_ok) begin
                rd_d = '0;
            end else if (!rd_addr[0]) begin
                rd_d      = sel_ext[63:32];
                shadow_ld = 1'b1;
                state_d   = RD_HELD;
            end else begin
                unique case (state_q)
                    RD_IDLE: rd_d = sel_ext[31:0];
                    RD_HELD: begin
                        if (idx == shadow_idx_q) begin
                            rd_d    = shadow_q;
                            state_d = RD_IDLE;
                        end else begin
                            rd_d = sel_ext[31:0];
                        end
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data      <= '0;
            shadow_q     <= '0;
            shadow_idx_q <= '0;
        end else begin
            rd_data <= rd_d;
            if (shadow_ld) begin
                shadow_q     <= sel_ext[31:0];
                shadow_idx_q <= idx;
            end
        end
    end

    assign rd_state = state_q;

endmodule

// File: rtl/eth_stat_counters.sv
module eth_stat_counters
    import eth_stat_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rpt_valid,
    input  logic                 rpt_is_tx,
    input  logic [LEN_W-1:0]     rpt_len,
    input  logic                 rpt_fcs_err,
    input  logic                 rpt_align_err,
    input  logic [1:0]           rpt_dst,
    input  logic                 rpt_vlan,
    input  logic                 rpt_pause,
    input  logic                 max_len_we,
    input  logic [LEN_W-1:0]     max_len_wdata,
    input  logic                 rd_en,
    input  logic [RD_ADDR_W-1:0] rd_addr,
    output logic [31:0]          rd_data
);

    logic [LEN_W-1:0]              max_len_q;
    logic [NUM_CNT-1:0]            inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    rd_state_e                     rd_state;

    always_ff @(posedge clk) begin
        if (!rst_n)          max_len_q <= LEN_W'(MAX_LEN_RST);
        else if (max_len_we) max_len_q <= max_len_wdata;
    end

    eth_stat_classify #(.LEN_W(LEN_W)) classify_i (
        .rpt_valid     (rpt_valid),
        .rpt_is_tx     (rpt_is_tx),
        .rpt_len       (rpt_len),
        .rpt_fcs_err   (rpt_fcs_err),
        .rpt_align_err (rpt_align_err),
        .rpt_dst       (rpt_dst),
        .rpt_vlan      (rpt_vlan),
        .rpt_pause     (rpt_pause),
        .max_len       (max_len_q),
        .inc           (inc)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic [LEN_W-1:0] add_val;
        if (g == IDX_OCT) begin : g_oct
            assign add_val = rpt_len;
        end else begin : g_one
            assign add_val = LEN_W'(1);
        end
        eth_stat_sat_cnt #(.CNT_W(CNT_W), .ADD_W(LEN_W)) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_en  (inc[g]),
            .add_val (add_val),
            .cnt_q   (cnt_q[g])
        );
    end

    eth_stat_rdport #(.CNT_W(CNT_W)) rdport_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .cnt_all  (cnt_q),
        .rd_data  (rd_data),
        .rd_state (rd_state)
    );

endmodule

// File: rtl/eth_stat_counters_chk.sv
module eth_stat_counters_chk
    import eth_stat_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int LEN_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          rpt_valid,
    input logic                          max_len_we,
    input logic [LEN_W-1:0]              max_len_wdata,
    input logic [LEN_W-1:0]              max_len_q,
    input logic                          rd_en,
    input logic [RD_ADDR_W-1:0]          rd_addr,
    input logic [31:0]                   rd_data,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
    input rd_state_e                     rd_state
);

    assert_quiet_counters_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_valid |=> $stable(cnt_q));

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_maxlen_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        max_len_we |=> (max_len_q == $past(max_len_wdata)));

    assert_upper_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_addr[0] && (int'(rd_addr[RD_ADDR_W-1:1]) < NUM_CNT))
        |=> (rd_state == RD_HELD));

    assert_one_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({cnt_q[IDX_UNI]   != $past(cnt_q[IDX_UNI]),
                              cnt_q[IDX_MULTI] != $past(cnt_q[IDX_MULTI]),
                              cnt_q[IDX_BCAST] != $past(cnt_q[IDX_BCAST])}) <= 1));

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt_chk
        assert_no_decrease_R4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt_q[g] >= $past(cnt_q[g])));
        assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == '1) |=> (cnt_q[g] == '1));
    end

endmodule

bind eth_stat_counters eth_stat_counters_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rpt_valid     (rpt_valid),
    .max_len_we    (max_len_we),
    .max_len_wdata (max_len_wdata),
    .max_len_q     (max_len_q),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .cnt_q         (cnt_q),
    .rd_state      (rd_state)
);

// File: tb/eth_stat_counters_tb_top.sv
`timescale 1ns/1ps
module eth_stat_counters_tb_top;

    localparam int BCW = 33;
    localparam longint unsigned SATV = (64'd1 << BCW) - 64'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rpt_valid = 0, rpt_is_tx = 0, rpt_fcs_err = 0, rpt_align_err = 0;
    logic        rpt_vlan = 0, rpt_pause = 0, max_len_we = 0, rd_en = 0;
    logic [15:0] rpt_len = 0, max_len_wdata = 0;
    logic [1:0]  rpt_dst = 0;
    logic [5:0]  rd_addr = 0;
    logic [31:0] rd_data;

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_req = "R1";

    longint unsigned m [22];
    longint unsigned maxm = 1536;
    longint unsigned exp_rd = 0;
    longint unsigned sh_val = 0;
    int  sh_idx = 0;
    bit  sh_vld = 0;

    always #4 clk = ~clk;

    eth_stat_counters #(.CNT_W(BCW), .LEN_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_is_tx(rpt_is_tx),
        .rpt_len(rpt_len), .rpt_fcs_err(rpt_fcs_err), .rpt_align_err(rpt_align_err),
        .rpt_dst(rpt_dst), .rpt_vlan(rpt_vlan), .rpt_pause(rpt_pause),
        .max_len_we(max_len_we), .max_len_wdata(max_len_wdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic bump(input int i, input longint unsigned a);
        if (m[i] > SATV - a) m[i] = SATV;
        else                 m[i] = m[i] + a;
    endtask

    // one clock: model reads with pre-edge values, then applies the report
    task automatic step();
        bit r = rd_en; int a = int'(rd_addr);
        bit v = rpt_valid, tx = rpt_is_tx, f = rpt_fcs_err, al = rpt_align_err;
        bit vl = rpt_vlan, p = rpt_pause, we = max_len_we;
        longint unsigned len = rpt_len, wd = max_len_wdata;
        int d = int'(rpt_dst);
        @(posedge clk);
        if (r) begin
            int idx = a >> 1;
            if (idx >= 22) exp_rd = 0;
            else if ((a & 1) == 0) begin
                exp_rd = m[idx] >> 32; sh_val = m[idx] & 64'hFFFF_FFFF;
                sh_vld = 1; sh_idx = idx;
            end else if (sh_vld && sh_idx == idx) begin
                exp_rd = sh_val; sh_vld = 0;
            end else exp_rd = m[idx] & 64'hFFFF_FFFF;
        end
        if (v && tx) begin
            bump(21, 1);
            if (p) bump(20, 1);
        end else if (v) begin
            bump(1, len);
            if (f)  bump(6, 1);
            if (al) bump(7, 1);
            if (len < 64) bump(f ? 9 : 8, 1);
            else if (len > maxm) bump(f ? 11 : 10, 1);
            else begin
                if (len == 64)        bump(12, 1);
                else if (len <= 127)  bump(13, 1);
                else if (len <= 255)  bump(14, 1);
                else if (len <= 511)  bump(15, 1);
                else if (len <= 1023) bump(16, 1);
                else if (len <= 1518) bump(17, 1);
                else                  bump(18, 1);
                if (!f && !al) begin
                    bump(0, 1);
                    if (d < 3) bump(2 + d, 1);
                    if (vl) bump(5, 1);
                    if (p)  bump(19, 1);
                end
            end
        end
        if (we) maxm = wd;
        @(negedge clk);
        chk(rd_data == exp_rd[31:0], cur_req, longint'(rd_data), exp_rd);
        rpt_valid = 0; rpt_is_tx = 0; rpt_fcs_err = 0; rpt_align_err = 0;
        rpt_vlan = 0; rpt_pause = 0; max_len_we = 0; rd_en = 0;
    endtask

    task automatic frame(input int len, input bit f, input bit al, input int d,
                         input bit vl, input bit p, input bit tx);
        rpt_valid = 1; rpt_len = 16'(len); rpt_fcs_err = f; rpt_align_err = al;
        rpt_dst = 2'(d); rpt_vlan = vl; rpt_pause = p; rpt_is_tx = tx;
        step();
    endtask

    task automatic rd(input int a);
        rd_en = 1; rd_addr = 6'(a);
        step();
    endtask

    task automatic read_all();
        for (int k = 0; k < 22; k++) begin
            rd(2 * k);
            rd(2 * k + 1);
        end
    endtask

    initial begin
        for (int k = 0; k < 22; k++) m[k] = 0;
        repeat (3) @(negedge clk);
        chk(rd_data == 32'd0, "R1", longint'(rd_data), 0);
        rst_n = 1;
        cur_req = "R1"; read_all();

        // length classes at boundaries
        cur_req = "R6"; frame(63, 0, 0, 0, 0, 0, 0); frame(63, 1, 0, 0, 0, 0, 0);
        frame(1, 0, 1, 0, 0, 0, 0);
        cur_req = "R5";
        frame(64, 0, 0, 0, 0, 0, 0);  frame(65, 0, 0, 1, 0, 0, 0);
        frame(127, 0, 0, 2, 1, 0, 0); frame(128, 1, 0, 0, 0, 0, 0);
        frame(255, 0, 1, 0, 0, 0, 0); frame(256, 0, 0, 3, 0, 0, 0);
        frame(511, 0, 0, 0, 0, 0, 0); frame(512, 0, 0, 1, 1, 0, 0);
        frame(1023, 0, 0, 0, 0, 0, 0); frame(1024, 0, 0, 2, 0, 0, 0);
        frame(1518, 0, 0, 0, 0, 0, 0); frame(1519, 0, 0, 0, 0, 0, 0);
        cur_req = "R1"; frame(1536, 0, 0, 0, 0, 0, 0);
        cur_req = "R7"; frame(1537, 0, 0, 0, 0, 0, 0); frame(1537, 1, 0, 0, 0, 0, 0);
        frame(9000, 1, 1, 0, 0, 0, 0);
        cur_req = "R8"; frame(700, 1, 1, 2, 1, 1, 0);
        cur_req = "R9"; frame(300, 0, 0, 2, 1, 0, 0); frame(90, 0, 0, 3, 1, 0, 0);
        cur_req = "R11"; frame(64, 0, 0, 1, 0, 1, 0); frame(64, 0, 0, 0, 0, 1, 1);
        frame(1500, 0, 0, 0, 0, 0, 1); frame(20000, 1, 1, 2, 1, 1, 1);
        cur_req = "R10"; read_all();

        // max length changes: report in the write cycle uses the old limit
        cur_req = "R12";
        max_len_we = 1; max_len_wdata = 16'd1518; frame(1530, 0, 0, 0, 0, 0, 0);
        frame(1519, 0, 0, 0, 0, 0, 0); frame(1518, 0, 0, 0, 0, 0, 0);
        max_len_we = 1; max_len_wdata = 16'd2000; step();
        frame(1900, 0, 0, 0, 0, 0, 0); frame(2001, 1, 0, 0, 0, 0, 0);
        read_all();

        // coherent split read while frames update the same counter
        cur_req = "R3";
        rd_en = 1; rd_addr = 6'd2; frame(1000, 0, 0, 0, 0, 0, 0);
        frame(800, 0, 0, 0, 0, 0, 0);
        rd(5);                       // lower of another counter: live
        rd_en = 1; rd_addr = 6'd3; frame(64, 0, 0, 0, 0, 0, 0);   // captured
        rd(3);                       // nothing held: live
        rd(0); rd(2); rd(1); rd(3);  // recapture switches counter
        cur_req = "R13";
        frame(100, 0, 0, 0, 0, 0, 0); rd(1);
        cur_req = "R2"; rd(44); rd(63); step(); step(); rd(43);

        // saturation of the octet counter
        cur_req = "R4";
        for (int k = 0; k < 131076; k++) frame(65535, 0, 0, 0, 0, 0, 0);
        rd(2); chk(rd_data == 32'd1, "R4", longint'(rd_data), 1);
        rd(3); chk(rd_data == 32'hFFFF_FFFF, "R4", longint'(rd_data), 64'hFFFF_FFFF);
        read_all();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule